// File: doc/BRIEF.md
# Gather Transmit DMA Sequencer

This block builds outgoing frames out of one or more host memory fragments. Software posts a transmit descriptor on behalf of a context (a queue slot owned by one producer). The descriptor gives a fragment address, a fragment length, a flag marking more fragments of the same frame, and a flag asking for checksum insertion. The sequencer serves contexts in the order they first posted. For the head context it waits until the transmit FIFO has room for the frame so far plus the next fragment. It then reads the fragment with a single DMA request and adds its length to a staging frame.

When the final fragment has landed, the staged frame is pushed into the transmit FIFO. The push carries the frame length and a checksum-request sideband bit, so a later stage computes the checksum. Each context has a completion word that reports busy while a descriptor is outstanding, and complete plus the copied length afterwards. Two event pulses report progress to an interrupt controller: one per finished fragment, and one when a push leaves the FIFO nearly full.

Top module: `gtx_gather_seq`

## Requirements
- R1: After reset the engine is idle, every completion word is zero, and dma_req, fifo_push, ev_txdma, ev_txfull and post_err are low.
- R2: A post to a context whose busy bit (completion word bit LW+1) is set is ignored: post_err pulses the next cycle, and the descriptor and the completion word stay unchanged.
- R3: An accepted post sets that context's completion word to busy only (bit LW+1 = 1, complete bit LW = 0, length [LW-1:0] = 0) in the cycle after the post.
- R4: Each fragment is fetched with a one-cycle dma_req carrying the descriptor's address and length, with at most one request outstanding until dma_done.
- R5: No fragment read starts while fifo_free minus the bytes already staged for the current frame is less than the fragment length.
- R6: After a fragment's dma_done, the context's completion word becomes complete (bit LW) with the fragment length in [LW-1:0] and the busy bit cleared.
- R7: A fragment posted with the more flag set raises ev_txdma, pushes nothing, and adds its length to the staged frame for the next fragment of the same context.
- R8: The final fragment causes one fifo_push whose fifo_len is the sum of all fragment lengths of the frame, with fifo_csum equal to the final descriptor's checksum flag, together with ev_txdma.
- R9: ev_txfull accompanies a push exactly when fifo_free minus the pushed frame length is below MAX_COPY.
- R10: Contexts are served in the order of their first post. A context that posts again while at the head of the queue is not queued a second time.

Ports (LW = clog2(MAX_FRAME+1), IW = clog2(NCTX), CW = LW+2):

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| post_valid | input | 1 | Descriptor post strobe |
| post_ctx | input | IW | Posting context index |
| post_addr | input | AW | Fragment host address |
| post_len | input | LW | Fragment length in bytes |
| post_more | input | 1 | More fragments of this frame follow |
| post_csum | input | 1 | Request checksum insertion for the frame |
| post_err | output | 1 | Pulse: post to a busy context was dropped |
| dma_req | output | 1 | One-cycle DMA read request |
| dma_addr | output | AW | DMA read address |
| dma_len | output | LW | DMA read length |
| dma_done | input | 1 | DMA read finished |
| fifo_free | input | FREE_W | Free bytes in the transmit FIFO |
| fifo_push | output | 1 | Push of a finished frame |
| fifo_len | output | LW | Length of the pushed frame |
| fifo_csum | output | 1 | Checksum-request sideband for the push |
| done_words | output | NCTX*CW | Completion words, context i at [i*CW +: CW] |
| ev_txdma | output | 1 | Pulse: a fragment finished |
| ev_txfull | output | 1 | Pulse: a push left the FIFO below MAX_COPY free |

## Verification
Frames are gathered from one, two and three fragments of different lengths on one context. This tells apart a correct staged sum and per-fragment event count from a design that pushes early or drops the staged bytes. The FIFO space is held one byte short of the staged-plus-fragment need and then raised to exactly that need, which separates the staged-aware space check from one that looks only at the fragment. Single-fragment frames are swept across the full-threshold boundary to pin down the comparison sense. Three contexts posted while the FIFO is closed, plus a repeated post to a busy context, show service order and that a rejected descriptor leaves no trace.

// File: rtl/gtx_pkg.sv
package gtx_pkg;
    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_FBLOCK = 3'd1,
        ST_BEGIN  = 3'd2,
        ST_COPY   = 3'd3,
        ST_CDONE  = 3'd4
    } gtx_state_e;
endpackage

// File: rtl/gtx_ctx_queue.sv
module gtx_ctx_queue #(
    parameter int NCTX = 4,
    localparam int IW = (NCTX > 1) ? $clog2(NCTX) : 1,
    localparam int CNT_W = $clog2(NCTX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic [IW-1:0]    push_idx_i,
    input  logic             pop_i,
    output logic [IW-1:0]    head_o,
    output logic             empty_o,
    output logic [CNT_W-1:0] count_o
);
    typedef struct packed {
        logic [NCTX-1:0][IW-1:0] slots;
        logic [IW-1:0]           rd;
        logic [IW-1:0]           wr;
        logic [CNT_W-1:0]        cnt;
    } queue_t;

    queue_t q_q, q_d;

    always_comb begin
        q_d = q_q;
        if (push_i) begin
            q_d.slots[q_q.wr] = push_idx_i;
            q_d.wr = (int'(q_q.wr) == NCTX - 1) ? '0 : q_q.wr + 1'b1;
        end
        if (pop_i) begin
            q_d.rd = (int'(q_q.rd) == NCTX - 1) ? '0 : q_q.rd + 1'b1;
        end
        q_d.cnt = q_q.cnt + CNT_W'(push_i) - CNT_W'(pop_i);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q_q <= '0;
        else        q_q <= q_d;
    end

    assign head_o  = q_q.slots[q_q.rd];
    assign empty_o = (q_q.cnt == '0);
    assign count_o = q_q.cnt;
endmodule

// File: rtl/gtx_ctx_bank.sv
module gtx_ctx_bank #(
    parameter int NCTX = 4,
    parameter int AW = 32,
    parameter int LW = 15,
    localparam int IW = (NCTX > 1) ? $clog2(NCTX) : 1,
    localparam int CW = LW + 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             post_we,
    input  logic [IW-1:0]    post_ctx,
    input  logic [AW-1:0]    post_addr,
    input  logic [LW-1:0]    post_len,
    input  logic             post_more,
    input  logic             post_csum,
    input  logic             done_we,
    input  logic [IW-1:0]    done_ctx,
    input  logic [LW-1:0]    done_len,
    input  logic [IW-1:0]    rd_ctx,
    output logic [AW-1:0]    rd_addr,
    output logic [LW-1:0]    rd_len,
    output logic             rd_more,
    output logic             rd_csum,
    output logic             rd_busy,
    output logic [NCTX-1:0]  busy_o,
    output logic [NCTX*CW-1:0] words_o
);
    typedef struct packed {
        logic          busy;
        logic          cmpl;
        logic [LW-1:0] wlen;
        logic [AW-1:0] addr;
        logic [LW-1:0] dlen;
        logic          more;
        logic          csum;
    } entry_t;

    entry_t [NCTX-1:0] e_q, e_d;

    always_comb begin
        e_d = e_q;
        if (done_we) begin
            e_d[done_ctx].busy = 1'b0;
            e_d[done_ctx].cmpl = 1'b1;
            e_d[done_ctx].wlen = done_len;
        end
        if (post_we) begin
            e_d[post_ctx].busy = 1'b1;
            e_d[post_ctx].cmpl = 1'b0;
            e_d[post_ctx].wlen = '0;
            e_d[post_ctx].addr = post_addr;
            e_d[post_ctx].dlen = post_len;
            e_d[post_ctx].more = post_more;
            e_d[post_ctx].csum = post_csum;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) e_q <= '0;
        else        e_q <= e_d;
    end

    for (genvar i = 0; i < NCTX; i++) begin : g_word
        assign words_o[i*CW +: CW] = {e_q[i].busy, e_q[i].cmpl, e_q[i].wlen};
        assign busy_o[i] = e_q[i].busy;
    end

    assign rd_addr = e_q[rd_ctx].addr;
    assign rd_len  = e_q[rd_ctx].dlen;
    assign rd_more = e_q[rd_ctx].more;
    assign rd_csum = e_q[rd_ctx].csum;
    assign rd_busy = e_q[rd_ctx].busy;
endmodule

// File: rtl/gtx_gather_seq.sv
module gtx_gather_seq #(
    parameter int NCTX = 4,
    parameter int AW = 32,
    parameter int MAX_FRAME = 16384,
    parameter int FREE_W = 16,
    parameter int MAX_COPY = 1024,
    localparam int LW = $clog2(MAX_FRAME + 1),
    localparam int IW = (NCTX > 1) ? $clog2(NCTX) : 1,
    localparam int CW = LW + 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               post_valid,
    input  logic [IW-1:0]      post_ctx,
    input  logic [AW-1:0]      post_addr,
    input  logic [LW-1:0]      post_len,
    input  logic               post_more,
    input  logic               post_csum,
    output logic               post_err,
    output logic               dma_req,
    output logic [AW-1:0]      dma_addr,
    output logic [LW-1:0]      dma_len,
    input  logic               dma_done,
    input  logic [FREE_W-1:0]  fifo_free,
    output logic               fifo_push,
    output logic [LW-1:0]      fifo_len,
    output logic               fifo_csum,
    output logic [NCTX*CW-1:0] done_words,
    output logic               ev_txdma,
    output logic               ev_txfull
);
    import gtx_pkg::*;

    localparam int SW = ((LW > FREE_W) ? LW : FREE_W) + 2;
    localparam int CNT_W = $clog2(NCTX + 1);

    typedef struct packed {
        gtx_state_e    st;
        logic [LW-1:0] staged;
        logic          err;
    } seq_t;

    seq_t s_q, s_d;

    logic [IW-1:0]    q_head;
    logic             q_empty, q_push, q_pop;
    logic [CNT_W-1:0] q_cnt;
    logic [AW-1:0]    rd_addr;
    logic [LW-1:0]    rd_len;
    logic             rd_more, rd_csum, rd_busy;
    logic [NCTX-1:0]  busy_vec;
    logic             accept, reject, head_match, space_ok, done_we;
    logic [LW-1:0]    fr_total;
    logic [SW-1:0]    have, need;

    gtx_ctx_queue #(.NCTX(NCTX)) u_queue (
        .clk(clk), .rst_n(rst_n),
        .push_i(q_push), .push_idx_i(post_ctx), .pop_i(q_pop),
        .head_o(q_head), .empty_o(q_empty), .count_o(q_cnt)
    );

    gtx_ctx_bank #(.NCTX(NCTX), .AW(AW), .LW(LW)) u_bank (
        .clk(clk), .rst_n(rst_n),
        .post_we(accept), .post_ctx(post_ctx), .post_addr(post_addr),
        .post_len(post_len), .post_more(post_more), .post_csum(post_csum),
        .done_we(done_we), .done_ctx(q_head), .done_len(rd_len),
        .rd_ctx(q_head), .rd_addr(rd_addr), .rd_len(rd_len),
        .rd_more(rd_more), .rd_csum(rd_csum), .rd_busy(rd_busy),
        .busy_o(busy_vec), .words_o(done_words)
    );

    assign accept     = post_valid && !busy_vec[post_ctx];
    assign reject     = post_valid &&  busy_vec[post_ctx];
    assign head_match = !q_empty && (q_head == post_ctx);
    assign q_push     = accept && !head_match;
    assign fr_total   = s_q.staged + rd_len;
    assign have       = SW'(fifo_free);
    assign need       = SW'(s_q.staged) + SW'(rd_len);
    assign space_ok   = (have >= need);

    assign done_we   = (s_q.st == ST_CDONE);
    assign dma_req   = (s_q.st == ST_BEGIN);
    assign dma_addr  = rd_addr;
    assign dma_len   = rd_len;
    assign fifo_push = done_we && !rd_more;
    assign fifo_len  = fr_total;
    assign fifo_csum = rd_csum;
    assign ev_txdma  = done_we;
    assign ev_txfull = fifo_push && (have < SW'(fr_total) + SW'(MAX_COPY));
    assign q_pop     = fifo_push;
    assign post_err  = s_q.err;

    always_comb begin
        s_d = s_q;
        s_d.err = reject;
        unique case (s_q.st)
            ST_IDLE:   if (accept && (q_empty || head_match)) s_d.st = ST_FBLOCK;
            ST_FBLOCK: if (rd_busy && space_ok) s_d.st = ST_BEGIN;
            ST_BEGIN:  s_d.st = ST_COPY;
            ST_COPY:   if (dma_done) s_d.st = ST_CDONE;
            ST_CDONE: begin
                if (rd_more) begin
                    s_d.staged = fr_total;
                    s_d.st     = ST_FBLOCK;
                end else begin
                    s_d.staged = '0;
                    s_d.st     = (q_cnt == CNT_W'(1) && !q_push) ? ST_IDLE : ST_FBLOCK;
                end
            end
            default:   s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{st: ST_IDLE, staged: '0, err: 1'b0};
        else        s_q <= s_d;
    end
endmodule

// File: rtl/gtx_gather_chk.sv
module gtx_gather_chk #(
    parameter int NCTX = 4,
    parameter int LW = 15,
    localparam int IW = (NCTX > 1) ? $clog2(NCTX) : 1,
    localparam int CW = LW + 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               post_valid,
    input logic [IW-1:0]      post_ctx,
    input logic               post_err,
    input logic               dma_req,
    input logic               dma_done,
    input logic               fifo_push,
    input logic               ev_txdma,
    input logic               ev_txfull,
    input logic [NCTX*CW-1:0] done_words
);
    logic outstanding;
    logic sel_busy;

    assign sel_busy = done_words[int'(post_ctx)*CW + CW - 1];

    always_ff @(posedge clk) begin
        if (!rst_n)        outstanding <= 1'b0;
        else if (dma_req)  outstanding <= 1'b1;
        else if (dma_done) outstanding <= 1'b0;
    end

    a_r2_busy_post_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        post_valid && sel_busy |=> post_err);

    a_r4_req_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        dma_req |=> !dma_req);

    a_r4_one_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
        !(outstanding && dma_req));

    a_r8_push_with_event: assert property (@(posedge clk) disable iff (!rst_n)
        fifo_push |-> ev_txdma);

    a_r9_full_needs_push: assert property (@(posedge clk) disable iff (!rst_n)
        ev_txfull |-> fifo_push);
endmodule

bind gtx_gather_seq gtx_gather_chk #(.NCTX(NCTX), .LW(LW)) u_chk (
    .clk(clk), .rst_n(rst_n), .post_valid(post_valid), .post_ctx(post_ctx),
    .post_err(post_err), .dma_req(dma_req), .dma_done(dma_done),
    .fifo_push(fifo_push), .ev_txdma(ev_txdma), .ev_txfull(ev_txfull),
    .done_words(done_words)
);

// File: tb/tb_gtx_gather_seq.sv
module tb_gtx_gather_seq;
    localparam int NCTX = 4;
    localparam int AW = 32;
    localparam int LW = 15;
    localparam int CW = LW + 2;
    localparam int MAXC = 64;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic post_valid = 1'b0;
    logic [1:0] post_ctx = '0;
    logic [AW-1:0] post_addr = '0;
    logic [LW-1:0] post_len = '0;
    logic post_more = 1'b0, post_csum = 1'b0;
    logic post_err, dma_req, dma_done = 1'b0;
    logic [AW-1:0] dma_addr;
    logic [LW-1:0] dma_len, fifo_len;
    logic [15:0] fifo_free = '0;
    logic fifo_push, fifo_csum, ev_txdma, ev_txfull;
    logic [NCTX*CW-1:0] done_words;

    int tests = 0, fails = 0;
    int nreq = 0, npush = 0, ndma = 0, nerr = 0;
    int req_addr [256];
    int req_len [256];
    int plen [256];
    bit pcsum [256];
    bit pfull [256];

    always #2 clk = ~clk;

    gtx_gather_seq #(.NCTX(NCTX), .AW(AW), .MAX_FRAME(16384), .FREE_W(16), .MAX_COPY(MAXC)) dut (
        .clk(clk), .rst_n(rst_n), .post_valid(post_valid), .post_ctx(post_ctx),
        .post_addr(post_addr), .post_len(post_len), .post_more(post_more),
        .post_csum(post_csum), .post_err(post_err), .dma_req(dma_req),
        .dma_addr(dma_addr), .dma_len(dma_len), .dma_done(dma_done),
        .fifo_free(fifo_free), .fifo_push(fifo_push), .fifo_len(fifo_len),
        .fifo_csum(fifo_csum), .done_words(done_words), .ev_txdma(ev_txdma),
        .ev_txfull(ev_txfull)
    );

    always @(negedge clk) begin
        if (dma_req) begin
            req_addr[nreq % 256] = int'(dma_addr);
            req_len[nreq % 256] = int'(dma_len);
            nreq++;
        end
        if (fifo_push) begin
            plen[npush % 256] = int'(fifo_len);
            pcsum[npush % 256] = fifo_csum;
            pfull[npush % 256] = ev_txfull;
            npush++;
        end
        if (ev_txdma) ndma++;
        if (post_err) nerr++;
    end

    initial begin
        forever begin
            @(negedge clk);
            if (dma_req) begin
                repeat (2) @(negedge clk);
                dma_done = 1'b1;
                @(negedge clk);
                dma_done = 1'b0;
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [CW-1:0] word(input int c);
        return done_words[c*CW +: CW];
    endfunction

    task automatic post(input int c, input int a, input int l, input bit m, input bit cs);
        post_valid = 1'b1;
        post_ctx = 2'(c);
        post_addr = AW'(a);
        post_len = LW'(l);
        post_more = m;
        post_csum = cs;
        @(negedge clk);
        post_valid = 1'b0;
    endtask

    task automatic wait_free(input int c);
        for (int i = 0; i < 2000; i++) begin
            if (!word(c)[CW-1]) break;
            @(negedge clk);
        end
        @(negedge clk);
    endtask

    task automatic wait_push(input int n);
        for (int i = 0; i < 4000; i++) begin
            if (npush >= n) break;
            @(negedge clk);
        end
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        int p0, d0, r0, e0, expsum;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(done_words == '0, "R1 words", int'(done_words[CW-1:0]), 0);
        check(!dma_req && !fifo_push && !ev_txdma && !ev_txfull && !post_err,
              "R1 outputs", int'(dma_req) + int'(fifo_push), 0);

        // single fragment, checksum requested
        fifo_free = 16'd4000;
        post(0, 'h1000, 100, 1'b0, 1'b1);
        check(word(0) == {1'b1, 1'b0, 15'd0}, "R3 busy word", int'(word(0)), 1 << (CW-1));
        wait_push(1);
        check(plen[0] == 100, "R8 frame len", plen[0], 100);
        check(pcsum[0] == 1'b1, "R8 csum flag", int'(pcsum[0]), 1);
        check(req_addr[0] == 'h1000, "R4 dma addr", req_addr[0], 'h1000);
        check(req_len[0] == 100, "R4 dma len", req_len[0], 100);
        wait_free(0);
        check(word(0) == {1'b0, 1'b1, 15'd100}, "R6 done word", int'(word(0)), (1 << LW) + 100);

        // gather sweep on one context: 1..3 fragments
        for (int n = 1; n <= 3; n++) begin
            p0 = npush; d0 = ndma; expsum = 0;
            for (int k = 0; k < n; k++) begin
                int l;
                l = 30 + 17 * k + n;
                expsum += l;
                post(1, 'h2000 + 256 * k, l, k < n - 1, n[0]);
                wait_free(1);
                check(word(1) == {1'b0, 1'b1, 15'(l)}, "R6 per fragment", int'(word(1)), (1 << LW) + l);
            end
            wait_push(p0 + 1);
            check(npush == p0 + 1, "R7 one push per frame", npush - p0, 1);
            check(plen[p0 % 256] == expsum, "R7 staged sum", plen[p0 % 256], expsum);
            check(pcsum[p0 % 256] == n[0], "R8 final csum", int'(pcsum[p0 % 256]), int'(n[0]));
            check(ndma - d0 == n, "R7 dma events", ndma - d0, n);
        end

        // post to busy context is dropped
        fifo_free = 16'd0;
        r0 = nreq; e0 = nerr; p0 = npush;
        post(2, 'h3000, 80, 1'b0, 1'b0);
        repeat (5) @(negedge clk);
        check(nreq == r0, "R5 stall on zero space", nreq - r0, 0);
        post(2, 'h3800, 90, 1'b0, 1'b1);
        @(negedge clk);
        check(nerr == e0 + 1, "R2 error pulse", nerr - e0, 1);
        check(word(2) == {1'b1, 1'b0, 15'd0}, "R2 word unchanged", int'(word(2)), 1 << (CW-1));
        fifo_free = 16'd4000;
        wait_push(p0 + 1);
        check(plen[p0 % 256] == 80, "R2 first descriptor kept", plen[p0 % 256], 80);
        check(pcsum[p0 % 256] == 1'b0, "R2 csum kept", int'(pcsum[p0 % 256]), 0);
        check(req_addr[r0 % 256] == 'h3000, "R2 addr kept", req_addr[r0 % 256], 'h3000);

        // space check includes staged bytes
        fifo_free = 16'd300;
        p0 = npush;
        post(3, 'h4000, 200, 1'b1, 1'b0);
        wait_free(3);
        r0 = nreq;
        post(3, 'h4100, 150, 1'b0, 1'b0);
        repeat (10) @(negedge clk);
        check(nreq == r0, "R5 staged stall", nreq - r0, 0);
        fifo_free = 16'd349;
        repeat (10) @(negedge clk);
        check(nreq == r0, "R5 one byte short", nreq - r0, 0);
        fifo_free = 16'd350;
        wait_push(p0 + 1);
        check(nreq == r0 + 1, "R5 released at exact fit", nreq - r0, 1);
        check(plen[p0 % 256] == 350, "R7 two-fragment frame", plen[p0 % 256], 350);
        check(pfull[p0 % 256] == 1'b1, "R9 full at zero left", int'(pfull[p0 % 256]), 1);

        // full-threshold sweep
        fifo_free = 16'd200;
        for (int l = 132; l <= 140; l++) begin
            bit expf;
            p0 = npush;
            expf = (200 - l) < MAXC;
            post(0, 'h5000, l, 1'b0, 1'b0);
            wait_push(p0 + 1);
            check(pfull[p0 % 256] == expf, "R9 threshold", int'(pfull[p0 % 256]), int'(expf));
            wait_free(0);
        end

        // service order across contexts
        fifo_free = 16'd0;
        p0 = npush; r0 = nreq;
        post(1, 'h6100, 10, 1'b0, 1'b0);
        post(0, 'h6000, 20, 1'b0, 1'b0);
        post(2, 'h6200, 30, 1'b0, 1'b0);
        check(word(0)[CW-1] == 1'b1, "R3 busy on queued post", int'(word(0)[CW-1]), 1);
        fifo_free = 16'd4000;
        wait_push(p0 + 3);
        check(plen[p0 % 256] == 10, "R10 order first", plen[p0 % 256], 10);
        check(plen[(p0 + 1) % 256] == 20, "R10 order second", plen[(p0 + 1) % 256], 20);
        check(plen[(p0 + 2) % 256] == 30, "R10 order third", plen[(p0 + 2) % 256], 30);
        check(req_addr[(r0 + 1) % 256] == 'h6000, "R10 addr order", req_addr[(r0 + 1) % 256], 'h6000);

        repeat (5) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule